// File: doc/BRIEF.md
# Filtered Interrupt Aggregator

This block collects four active-low interrupt requests, one from each downstream bus segment of a bus switch, and merges them into one shared active-low request toward the host. Each request line first passes a two-flop synchronizer and then a glitch filter. The filter rejects low pulses shorter than one width and high gaps shorter than a second, smaller width. Both widths are set as clock-cycle counts. The merged output is low whenever any filtered line is low. It is intended to drive an open-drain pad, where a high level means released.

The block also supplies the byte returned by a control-register read. The upper nibble reports which channels hold a pending request, and the lower nibble reflects the current channel-select bits. The whole byte is captured on a single load strobe, issued when the read byte is loaded for shift-out, and it holds until the next strobe. A request is detected whether or not its channel is selected.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, `irq_no` is high, `rd_byte_o` is 0, and every channel counts as idle (filtered high).
- R2: `irq_no` goes low one cycle after any filtered channel goes low. It returns high one cycle after all filtered channels are high again.
- R3: The value of `ch_sel_i` has no effect on detection. A request on a deselected channel asserts `irq_no` just as a request on a selected channel does.
- R4: On a cycle with `rd_load_i` high, the next edge loads `rd_byte_o`. Bit 4+n is 1 when channel n is filtered low (pending), and bits 3:0 take `ch_sel_i`.
- R5: A low pulse on `irq_ni[n]` that lasts fewer than `LOW_REJ_CYC` clock cycles never asserts `irq_no`.
- R6: While a channel is pending, a high gap shorter than `HIGH_REJ_CYC` cycles does not release it.
- R7: A low level held for at least `LOW_REJ_CYC` cycles asserts `irq_no` after exactly `LOW_REJ_CYC`+3 clock edges. A release held for at least `HIGH_REJ_CYC` cycles releases it after `HIGH_REJ_CYC`+3 edges.
- R8: Between load strobes, `rd_byte_o` holds its value, even while the inputs change.
- R9: Several channels may be pending at once, and the upper nibble then shows all of them. `irq_no` stays low until the last pending channel is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_ni | input | N_CH | Active-low per-channel interrupt requests, asynchronous |
| ch_sel_i | input | N_CH | Current channel-select bits, reported in the read byte |
| rd_load_i | input | 1 | Captures the read byte at the next edge |
| irq_no | output | 1 | Merged active-low request; high means released |
| rd_byte_o | output | 2*N_CH | Captured read byte: pending flags above, select bits below |

## Verification
A filter counter that is stuck or loaded wrongly shows at `irq_no`. The request then arrives early, late, or not at all, relative to the fixed `LOW_REJ_CYC`+3 edge latency. It may also let through a pulse one or two cycles shorter than the limit, which is why the checks sample just before and just after that boundary. A filtered state that disagrees with the inputs also shows in the upper nibble at the next read load. A capture register that is not held shows as a changed `rd_byte_o` within a filter delay of the next input change.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  function automatic int cnt_width(input int a, input int b);
    int m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/irq_glitch_filter.sv
module irq_glitch_filter #(
  parameter int LOW_CYC  = 100,
  parameter int HIGH_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_ni,
  output logic sync_o,
  output logic flt_o
);
  localparam int CW = irq_agg_pkg::cnt_width(LOW_CYC, HIGH_CYC);
  localparam logic [CW-1:0] LOW_LAST  = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] HIGH_LAST = CW'(HIGH_CYC - 1);

  logic          s;
  logic          flt_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  irq_sync i_sync (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw_ni), .q_o(s));

  // idle (high) state needs the long low run to flip, pending needs the short high run
  assign last = flt_q ? LOW_LAST : HIGH_LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_q <= 1'b1;
      cnt_q <= '0;
    end else if (s == flt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == last) begin
      flt_q <= s;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sync_o = s;
  assign flt_o  = flt_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int N_CH         = 4,
  parameter int LOW_REJ_CYC  = 100,
  parameter int HIGH_REJ_CYC = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   irq_ni,
  input  logic [N_CH-1:0]   ch_sel_i,
  input  logic              rd_load_i,
  output logic              irq_no,
  output logic [2*N_CH-1:0] rd_byte_o
);
  logic [N_CH-1:0]   sync_w;
  logic [N_CH-1:0]   flt_w;
  logic              irq_q;
  logic [2*N_CH-1:0] rd_q;

  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    irq_glitch_filter #(.LOW_CYC(LOW_REJ_CYC), .HIGH_CYC(HIGH_REJ_CYC)) i_flt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_ni(irq_ni[n]),
      .sync_o(sync_w[n]),
      .flt_o (flt_w[n])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b1;
      rd_q  <= '0;
    end else begin
      irq_q <= &flt_w;
      if (rd_load_i) rd_q <= {~flt_w, ch_sel_i};
    end
  end

  assign irq_no    = irq_q;
  assign rd_byte_o = rd_q;
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int N_CH         = 4,
  parameter int LOW_REJ_CYC  = 100,
  parameter int HIGH_REJ_CYC = 50
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_CH-1:0]   ch_sel_i,
  input logic              rd_load_i,
  input logic              irq_no,
  input logic [2*N_CH-1:0] rd_byte_o,
  input logic [N_CH-1:0]   sync_i,
  input logic [N_CH-1:0]   flt_i
);
  localparam int CW = irq_agg_pkg::cnt_width(LOW_REJ_CYC, HIGH_REJ_CYC);
  localparam logic [CW-1:0] LO_SAT = CW'(LOW_REJ_CYC);
  localparam logic [CW-1:0] HI_SAT = CW'(HIGH_REJ_CYC);

  p_out_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&flt_i) |=> !irq_no);
  p_out_rel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&flt_i) |=> irq_no);
  p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_load_i |=> rd_byte_o == {~$past(flt_i), $past(ch_sel_i)});
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_load_i |=> $stable(rd_byte_o));

  for (genvar n = 0; n < N_CH; n++) begin : g_run
    logic [CW-1:0] run_lo_q, run_hi_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        run_lo_q <= '0;
        run_hi_q <= '0;
      end else begin
        run_lo_q <= sync_i[n] ? '0 : ((run_lo_q == LO_SAT) ? run_lo_q : run_lo_q + 1'b1);
        run_hi_q <= !sync_i[n] ? '0 : ((run_hi_q == HI_SAT) ? run_hi_q : run_hi_q + 1'b1);
      end
    end
    p_low_rej_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flt_i[n]) |-> run_lo_q >= LO_SAT);
    p_high_rej_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flt_i[n]) |-> run_hi_q >= HI_SAT);
  end
endmodule

bind irq_aggregator irq_aggregator_chk #(
  .N_CH(N_CH), .LOW_REJ_CYC(LOW_REJ_CYC), .HIGH_REJ_CYC(HIGH_REJ_CYC)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ch_sel_i (ch_sel_i),
  .rd_load_i(rd_load_i),
  .irq_no   (irq_no),
  .rd_byte_o(rd_byte_o),
  .sync_i   (sync_w),
  .flt_i    (flt_w)
);

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  localparam int N  = 4;
  localparam int LO = 100;
  localparam int HI = 50;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_n = '1;
  logic [N-1:0] sel = '0;
  logic         rd_load = 1'b0;
  logic         irq_o;
  logic [7:0]   rd_byte;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  irq_aggregator #(.N_CH(N), .LOW_REJ_CYC(LO), .HIGH_REJ_CYC(HI)) i_irq_aggregator (
    .clk_i(clk), .rst_ni(rst_n), .irq_ni(irq_n), .ch_sel_i(sel),
    .rd_load_i(rd_load), .irq_no(irq_o), .rd_byte_o(rd_byte)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // every cycle for n cycles, irq_o must equal v
  task automatic watch(input string tag, input int n, input logic v);
    logic ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq_o !== v) ok = 1'b0;
    end
    chk(tag, {7'd0, ok}, 8'd1);
  endtask

  task automatic do_read();
    rd_load = 1'b1;
    @(negedge clk);
    rd_load = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 irq after reset", {7'd0, irq_o}, 8'd1);
    chk("R1 byte after reset", rd_byte, 8'h00);
    do_read();
    chk("R1 idle channels", rd_byte, 8'h00);
  endtask

  task automatic t_short_low();
    irq_n[0] = 1'b0;
    cyc(LO - 2);
    irq_n[0] = 1'b1;
    watch("R5 short low rejected", LO + 10, 1'b1);
  endtask

  task automatic t_assert_latency();
    sel = 4'b0001;
    irq_n[1] = 1'b0;   // channel 1 not selected
    cyc(LO + 2);
    chk("R7 not yet asserted", {7'd0, irq_o}, 8'd1);
    cyc(1);
    chk("R7 R3 asserted at limit+3", {7'd0, irq_o}, 8'd0);
    do_read();
    chk("R4 read pending ch1", rd_byte, 8'h21);
  endtask

  task automatic t_short_high();
    irq_n[1] = 1'b1;
    cyc(HI - 2);
    irq_n[1] = 1'b0;
    watch("R6 short high gap ignored", HI + 10, 1'b0);
  endtask

  task automatic t_release();
    irq_n[1] = 1'b1;
    cyc(HI + 2);
    chk("R7 release not yet", {7'd0, irq_o}, 8'd0);
    cyc(1);
    chk("R7 released at limit+3", {7'd0, irq_o}, 8'd1);
  endtask

  task automatic t_multi();
    sel = 4'b1010;
    irq_n[0] = 1'b0;
    irq_n[3] = 1'b0;
    cyc(LO + 6);
    chk("R2 asserted two channels", {7'd0, irq_o}, 8'd0);
    do_read();
    chk("R9 R4 both pending", rd_byte, 8'h9A);
    irq_n[0] = 1'b1;
    cyc(HI + 6);
    chk("R9 still low with ch3", {7'd0, irq_o}, 8'd0);
    chk("R8 byte held", rd_byte, 8'h9A);
    irq_n[3] = 1'b1;
    cyc(HI + 6);
    chk("R2 released all idle", {7'd0, irq_o}, 8'd1);
    chk("R8 byte held after release", rd_byte, 8'h9A);
    do_read();
    chk("R4 fresh read idle", rd_byte, 8'h0A);
  endtask

  task automatic t_all_sel_off();
    sel = 4'b0000;
    irq_n[2] = 1'b0;
    cyc(LO + 6);
    chk("R3 deselected ch2 detected", {7'd0, irq_o}, 8'd0);
    do_read();
    chk("R4 ch2 at bit6", rd_byte, 8'h40);
    irq_n[2] = 1'b1;
    cyc(HI + 6);
    chk("R2 ch2 released", {7'd0, irq_o}, 8'd1);
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL R0 watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_short_low();
    t_assert_latency();
    t_short_high();
    t_release();
    t_multi();
    t_all_sel_off();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule